// File: doc/BRIEF.md
# Memory Ordering Issue Controller

This block stands between one processor's in-order stream of memory requests and a memory system that may finish them in any order. For each request at the head of the stream it decides whether the request may be issued now. The decision depends on the kinds of access still in flight and on an ordering mode chosen at run time: a strict mode where every access waits for its predecessor, a weak mode where synchronization accesses act as full fences, and a release mode where acquire and release are one-sided barriers.

A request is offered with a valid/ready handshake. The block accepts it only when the active mode allows it. It gives the request the lowest free slot number as its completion ID and presents it on the issue port one cycle later. The memory system later returns that ID on the response port, and the slot is then freed. The block tracks every outstanding access in a slot table whose depth is a parameter. The ordering mode can be changed only while nothing is outstanding.

Top module: `mo_issue_ctrl`

## Requirements
- R1: After reset `out_cnt` is 0, `iss_valid` is low and `mode_cur` is 0 (strict mode).
- R2: A request accepted on a clock edge (`req_valid` and `req_ready` both high) appears on the issue port in the following cycle with its op code and tag. Its `iss_id` is the lowest-numbered slot that was free before that edge. When no request was accepted, `iss_valid` is low.
- R3: `out_cnt` rises by one for each accepted request and falls by one for each `rsp_valid` whose `rsp_id` names an outstanding slot. A response naming a free slot is ignored. Responses may arrive in any order. With DEPTH accesses outstanding, `req_ready` is low.
- R4: In strict mode (`mode_cur` 0 or 3), `req_ready` is high only when nothing is outstanding.
- R5: In weak mode (`mode_cur` 1), a synchronization op (op code 2 acquire, 3 release, 4 fence, and codes 5 to 7, which are treated as fences) is ready only when nothing is outstanding.
- R6: In weak mode, no op is ready while any synchronization op is outstanding. Loads (code 0) and stores (code 1) are otherwise ready even while other data accesses are outstanding.
- R7: In release mode (`mode_cur` 2), no op is ready while an acquire is outstanding. Loads and stores are ready while only releases and data accesses are outstanding.
- R8: In release mode, an acquire is ready only when no synchronization op is outstanding. Outstanding data accesses do not hold it back.
- R9: In release mode, a release or fence is ready only when nothing is outstanding.
- R10: While `mode_sel` differs from `mode_cur`, `req_ready` is low. `mode_cur` takes the value of `mode_sel` on the first edge at which nothing is outstanding, and it never changes while accesses are outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Requested ordering mode: 0/3 strict, 1 weak, 2 release |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | The offered request may be accepted this cycle |
| req_op | input | 3 | Op code: 0 load, 1 store, 2 acquire, 3 release, 4 to 7 fence |
| req_tag | input | TAG_W | Tag carried through to the issue port |
| iss_valid | output | 1 | An issued request is present |
| iss_op | output | 3 | Op code of the issued request |
| iss_tag | output | TAG_W | Tag of the issued request |
| iss_id | output | ID_W | Completion ID (slot) of the issued request |
| rsp_valid | input | 1 | A completion is returned |
| rsp_id | input | ID_W | ID of the completed request |
| out_cnt | output | CNT_W | Number of outstanding accesses |
| mode_cur | output | 2 | Ordering mode now in force |

## Verification
The bench builds the block with DEPTH 4 and TAG_W 6. The small table fills after four issues, so the saturation stall, the lowest-free-slot choice after completions out of order, and the reuse of freed slots come up often. Long random runs in each mode then meet many mixes of outstanding data, acquire and release. Mode changes are requested at random while accesses are in flight, which exercises the drain-before-switch rule.

// File: rtl/mo_pkg.sv
package mo_pkg;

  localparam logic [1:0] MD_STRICT = 2'd0;
  localparam logic [1:0] MD_WEAK   = 2'd1;
  localparam logic [1:0] MD_RELACQ = 2'd2;

  localparam logic [2:0] OP_LOAD  = 3'd0;
  localparam logic [2:0] OP_STORE = 3'd1;
  localparam logic [2:0] OP_ACQ   = 3'd2;
  localparam logic [2:0] OP_REL   = 3'd3;

  // summary of the slot table seen by the ordering rules
  typedef struct packed {
    logic any;       // at least one access outstanding
    logic full;      // every slot in use
    logic sync_any;  // a synchronization op outstanding
    logic acq_any;   // an acquire outstanding
  } occ_t;

  function automatic logic op_is_sync(input logic [2:0] op);
    return op >= OP_ACQ;
  endfunction

  function automatic logic op_is_acq(input logic [2:0] op);
    return op == OP_ACQ;
  endfunction

endpackage

// File: rtl/mo_slot_table.sv
module mo_slot_table #(
  parameter int DEPTH = 8,
  parameter int ID_W  = 3,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alloc_en,
  input  logic             alloc_sync,
  input  logic             alloc_acq,
  input  logic             free_en,
  input  logic [ID_W-1:0]  free_id,
  output logic [ID_W-1:0]  alloc_id,
  output logic [CNT_W-1:0] count,
  output mo_pkg::occ_t     occ
);
  logic [DEPTH-1:0] busy_q, sync_q, acq_q;
  logic [DEPTH-1:0] set_v, clr_v;

  // lowest free slot
  always_comb begin
    alloc_id = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!busy_q[i]) alloc_id = ID_W'(i);
    end
  end

  // per-slot set/clear decode
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    assign set_v[g] = alloc_en && (alloc_id == ID_W'(g));
    assign clr_v[g] = free_en && (free_id == ID_W'(g)) && busy_q[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= '0;
      sync_q <= '0;
      acq_q  <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (set_v[i]) begin
          busy_q[i] <= 1'b1;
          sync_q[i] <= alloc_sync;
          acq_q[i]  <= alloc_acq;
        end else if (clr_v[i]) begin
          busy_q[i] <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    count = '0;
    for (int i = 0; i < DEPTH; i++) count = count + CNT_W'(busy_q[i]);
  end

  assign occ.any      = |busy_q;
  assign occ.full     = &busy_q;
  assign occ.sync_any = |(busy_q & sync_q);
  assign occ.acq_any  = |(busy_q & acq_q);

endmodule

// File: rtl/mo_order_gate.sv
module mo_order_gate (
  input  logic [1:0]   mode,
  input  logic [2:0]   op,
  input  mo_pkg::occ_t occ,
  output logic         ok
);
  import mo_pkg::*;

  logic is_sync, is_acq;
  assign is_sync = op_is_sync(op);
  assign is_acq  = op_is_acq(op);

  always_comb begin
    ok = 1'b0;
    if (!occ.full) begin
      case (mode)
        MD_WEAK:   ok = is_sync ? !occ.any : !occ.sync_any;
        MD_RELACQ: begin
          if (occ.acq_any)  ok = 1'b0;
          else if (!is_sync) ok = 1'b1;
          else if (is_acq)  ok = !occ.sync_any;
          else              ok = !occ.any;
        end
        default:   ok = !occ.any;
      endcase
    end
  end

endmodule

// File: rtl/mo_mode_ctrl.sv
module mo_mode_ctrl (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode_sel,
  input  logic       idle,
  output logic [1:0] mode_q,
  output logic       match
);
  always_ff @(posedge clk) begin
    if (rst)                              mode_q <= mo_pkg::MD_STRICT;
    else if (idle && mode_sel != mode_q)  mode_q <= mode_sel;
  end

  assign match = (mode_sel == mode_q);

endmodule

// File: rtl/mo_issue_ctrl.sv
module mo_issue_ctrl #(
  parameter int DEPTH = 8,
  parameter int TAG_W = 8,
  localparam int ID_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode_sel,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [2:0]       req_op,
  input  logic [TAG_W-1:0] req_tag,
  output logic             iss_valid,
  output logic [2:0]       iss_op,
  output logic [TAG_W-1:0] iss_tag,
  output logic [ID_W-1:0]  iss_id,
  input  logic             rsp_valid,
  input  logic [ID_W-1:0]  rsp_id,
  output logic [CNT_W-1:0] out_cnt,
  output logic [1:0]       mode_cur
);
  import mo_pkg::*;

  occ_t            occ;
  logic [ID_W-1:0] slot_id;
  logic            rule_ok, mode_match, accept;

  mo_slot_table #(.DEPTH(DEPTH), .ID_W(ID_W), .CNT_W(CNT_W)) u_slots (
    .clk(clk), .rst(rst),
    .alloc_en(accept), .alloc_sync(op_is_sync(req_op)), .alloc_acq(op_is_acq(req_op)),
    .free_en(rsp_valid), .free_id(rsp_id),
    .alloc_id(slot_id), .count(out_cnt), .occ(occ)
  );

  mo_order_gate u_gate (.mode(mode_cur), .op(req_op), .occ(occ), .ok(rule_ok));

  mo_mode_ctrl u_mode (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .idle(!occ.any),
    .mode_q(mode_cur), .match(mode_match)
  );

  assign req_ready = mode_match && rule_ok;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      iss_valid <= 1'b0;
      iss_op    <= '0;
      iss_tag   <= '0;
      iss_id    <= '0;
    end else begin
      iss_valid <= accept;
      if (accept) begin
        iss_op  <= req_op;
        iss_tag <= req_tag;
        iss_id  <= slot_id;
      end
    end
  end

endmodule

// File: rtl/mo_issue_ctrl_chk.sv
module mo_issue_ctrl_chk #(
  parameter int DEPTH = 8,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       mode_sel,
  input logic [1:0]       mode_cur,
  input logic             req_valid,
  input logic             req_ready,
  input logic [2:0]       req_op,
  input logic             iss_valid,
  input logic [CNT_W-1:0] out_cnt
);
  p_iss_after_accept_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> iss_valid);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    out_cnt <= CNT_W'(DEPTH));

  p_full_stall_r3: assert property (@(posedge clk) disable iff (rst)
    (out_cnt == CNT_W'(DEPTH)) |-> !req_ready);

  p_strict_wait_r4: assert property (@(posedge clk) disable iff (rst)
    ((mode_cur == 2'd0 || mode_cur == 2'd3) && out_cnt != '0) |-> !req_ready);

  p_weak_fence_r5: assert property (@(posedge clk) disable iff (rst)
    (mode_cur == 2'd1 && req_op >= 3'd2 && out_cnt != '0) |-> !req_ready);

  p_relfence_r9: assert property (@(posedge clk) disable iff (rst)
    (mode_cur == 2'd2 && req_op >= 3'd3 && out_cnt != '0) |-> !req_ready);

  p_mode_block_r10: assert property (@(posedge clk) disable iff (rst)
    (mode_sel != mode_cur) |-> !req_ready);

  p_mode_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (out_cnt != '0) |=> $stable(mode_cur));

endmodule

bind mo_issue_ctrl mo_issue_ctrl_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .mode_sel(mode_sel), .mode_cur(mode_cur),
  .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
  .iss_valid(iss_valid), .out_cnt(out_cnt)
);

// File: tb/sim_mo_issue_ctrl.sv
module sim_mo_issue_ctrl;
  localparam int DEPTH = 4;
  localparam int TAG_W = 6;
  localparam int ID_W  = 2;
  localparam int CNT_W = 3;

  logic clk = 1'b0;
  logic rst;
  logic [1:0] mode_sel;
  logic req_valid, req_ready;
  logic [2:0] req_op;
  logic [TAG_W-1:0] req_tag;
  logic iss_valid;
  logic [2:0] iss_op;
  logic [TAG_W-1:0] iss_tag;
  logic [ID_W-1:0] iss_id;
  logic rsp_valid;
  logic [ID_W-1:0] rsp_id;
  logic [CNT_W-1:0] out_cnt;
  logic [1:0] mode_cur;

  always #5 clk = ~clk;

  mo_issue_ctrl #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u0 (.*);

  int checks = 0;
  int errors = 0;

  // reference state: outstanding accesses by ID and their kinds
  bit m_busy [DEPTH];
  bit m_sync [DEPTH];
  bit m_acq  [DEPTH];
  int m_mode = 0;
  bit e_iss_v = 0;
  int e_iss_op, e_iss_tag, e_iss_id;

  function automatic int m_count();
    int c = 0;
    for (int i = 0; i < DEPTH; i++) c += int'(m_busy[i]);
    return c;
  endfunction
  function automatic bit m_any_sync();
    for (int i = 0; i < DEPTH; i++) if (m_busy[i] && m_sync[i]) return 1;
    return 0;
  endfunction
  function automatic bit m_any_acq();
    for (int i = 0; i < DEPTH; i++) if (m_busy[i] && m_acq[i]) return 1;
    return 0;
  endfunction
  function automatic int m_low_free();
    for (int i = 0; i < DEPTH; i++) if (!m_busy[i]) return i;
    return 0;
  endfunction

  function automatic bit exp_ready(int op, int msel);
    bit s = (op >= 2);
    if (msel != m_mode) return 0;
    if (m_count() == DEPTH) return 0;
    if (m_mode == 1) return s ? (m_count() == 0) : !m_any_sync();
    if (m_mode == 2) begin
      if (m_any_acq()) return 0;
      if (!s) return 1;
      if (op == 2) return !m_any_sync();
      return m_count() == 0;
    end
    return m_count() == 0;
  endfunction

  function automatic string rule_tag(int op, int msel);
    if (msel != m_mode) return "R10";
    if (m_count() == DEPTH) return "R3";
    if (m_mode == 1) return (op >= 2) ? "R5" : "R6";
    if (m_mode == 2) begin
      if (m_any_acq() || op < 2) return "R7";
      return (op == 2) ? "R8" : "R9";
    end
    return "R4";
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // one cycle: drive, compare before the edge, update the model after it
  task automatic step(bit v, int op, int tag, bit rv, int rid, int msel);
    bit er;
    int pre_cnt, nid;
    req_valid = v; req_op = 3'(op); req_tag = TAG_W'(tag);
    rsp_valid = rv; rsp_id = ID_W'(rid); mode_sel = 2'(msel);
    #1;
    er = exp_ready(op, msel);
    chk(req_ready == er, rule_tag(op, msel), "req_ready", int'(req_ready), int'(er));
    chk(int'(out_cnt) == m_count(), "R3", "out_cnt", int'(out_cnt), m_count());
    chk(int'(mode_cur) == m_mode, "R10", "mode_cur", int'(mode_cur), m_mode);
    chk(iss_valid == e_iss_v, "R2", "iss_valid", int'(iss_valid), int'(e_iss_v));
    if (e_iss_v) begin
      chk(int'(iss_op) == e_iss_op, "R2", "iss_op", int'(iss_op), e_iss_op);
      chk(int'(iss_tag) == e_iss_tag, "R2", "iss_tag", int'(iss_tag), e_iss_tag);
      chk(int'(iss_id) == e_iss_id, "R2", "iss_id", int'(iss_id), e_iss_id);
    end
    @(posedge clk);
    pre_cnt = m_count();
    e_iss_v = v && er;
    if (e_iss_v) begin
      nid = m_low_free();
      e_iss_op = op; e_iss_tag = tag; e_iss_id = nid;
    end
    if (rv && m_busy[rid]) m_busy[rid] = 0;
    if (e_iss_v) begin
      m_busy[nid] = 1; m_sync[nid] = (op >= 2); m_acq[nid] = (op == 2);
    end
    if (pre_cnt == 0 && msel != m_mode) m_mode = msel;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
  end

  initial begin
    int cur_mode;
    rst = 1; req_valid = 0; req_op = 0; req_tag = 0;
    rsp_valid = 0; rsp_id = 0; mode_sel = 0;
    for (int i = 0; i < DEPTH; i++) begin m_busy[i] = 0; m_sync[i] = 0; m_acq[i] = 0; end
    repeat (3) @(posedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(out_cnt == '0, "R1", "out_cnt after reset", int'(out_cnt), 0);
    chk(iss_valid == 1'b0, "R1", "iss_valid after reset", int'(iss_valid), 0);
    chk(mode_cur == 2'd0, "R1", "mode_cur after reset", int'(mode_cur), 0);

    // R4 strict: store, then load must wait until completion
    step(1, 1, 5, 0, 0, 0);
    step(1, 0, 6, 0, 0, 0);
    step(1, 0, 6, 1, 0, 0);
    step(1, 0, 6, 0, 0, 0);
    step(0, 0, 0, 1, 0, 0);
    // R10 switch to weak, then R3/R2 fill and out-of-order drain
    step(0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 1);
    for (int i = 0; i < DEPTH + 1; i++) step(1, 1, 10 + i, 0, 0, 1);
    step(1, 0, 20, 1, 2, 1);
    step(0, 0, 0, 1, 1, 1);
    step(1, 1, 21, 1, 1, 1);
    step(1, 0, 22, 0, 0, 1);
    // R5/R6: fence waits for all, then blocks everything
    for (int i = 0; i < DEPTH; i++) step(1, 4, 30, 1, i, 1);
    step(1, 4, 30, 0, 0, 1);
    step(1, 0, 31, 0, 0, 1);
    step(1, 0, 31, 1, 0, 1);
    // R10 switch to release while busy: held until drained
    step(1, 1, 32, 0, 0, 2);
    step(0, 0, 0, 1, 0, 2);
    step(0, 0, 0, 0, 0, 2);
    // R7/R8/R9 in release mode
    step(1, 0, 40, 0, 0, 2);
    step(1, 2, 41, 0, 0, 2);
    step(1, 3, 42, 0, 0, 2);
    step(1, 0, 43, 1, 1, 2);
    step(1, 3, 44, 1, 0, 2);
    step(1, 0, 45, 0, 0, 2);
    step(1, 2, 46, 0, 0, 2);
    step(1, 2, 46, 1, 0, 2);
    step(1, 0, 47, 1, 1, 2);
    step(1, 0, 47, 0, 0, 2);

    // random mix with occasional mode changes
    cur_mode = 2;
    for (int n = 0; n < 12000; n++) begin
      if ($urandom_range(0, 199) == 0) cur_mode = $urandom_range(0, 3);
      step($urandom_range(0, 2) != 0, $urandom_range(0, 7), $urandom_range(0, 63),
           $urandom_range(0, 1) == 1, $urandom_range(0, DEPTH - 1), cur_mode);
    end
    summary();
  end

endmodule